// File: doc/BRIEF.md
# Bus Target Read Responder

This block is the read side of a target on a multiplexed 32-bit address/data bus. It watches for the start of a bus cycle and captures the address and command on that edge. It claims the cycle when the command is a memory read and the address falls inside a configured window. It then waits out one turnaround clock, so that the initiator can stop driving the shared lines. After that it returns data words, one per handshake, which it fetches from a local read port.

The local side sees a request, a word address and a ready/data pair. When the local side is not ready, the target holds its ready line off, which inserts wait states. The initiator marks the final word by ending the cycle indication while it is ready. Once that word has moved, the target releases every line it drove. A parity bit follows the driven data one clock later. It is even parity over the 32 data bits and the 4 command/byte-enable bits, and it ignores whether each byte lane is enabled.

The bus lines are active low. The shared data lines and the parity line are shown as separate value and output-enable signals, and the pads are outside this block.

Top module: `bus_read_target`

## Requirements
- R1: While reset is held and on the first clock after it, `sel_n` and `slv_rdy_n` are 1 and `ad_oe` and `par_oe` are 0.
- R2: The block claims a cycle by driving `sel_n` to 0 from the second clock edge after the start edge. It claims only when the command on `cbe_i` at the start edge is 4'b0110, 4'b1100 or 4'b1110, and when `ad_i[31:WIN_BITS]` equals `BASE_ADDR[31:WIN_BITS]`. Any other cycle leaves `sel_n` at 1 and `ad_oe` at 0.
- R3: In the clock that follows the start edge (the turnaround), `sel_n` and `slv_rdy_n` stay at 1 and `ad_oe` stays at 0. The earliest a data word can appear is the clock after that.
- R4: `ad_oe` is 1 exactly while `sel_n` is 0, and `slv_rdy_n` is 0 only while the cycle is claimed.
- R5: A word transfers only on an edge where both `slv_rdy_n` and `mst_rdy_n` are 0. While `slv_rdy_n` is 0 and `mst_rdy_n` is 1, `ad_o` and `slv_rdy_n` hold. Each claimed cycle moves exactly as many words as the initiator takes.
- R6: `slv_rdy_n` goes to 0 for a new word only after an edge where `rd_valid` was 1. While the local port is not ready, `slv_rdy_n` stays at 1.
- R7: Successive words come from `rd_addr` values that start at the captured address with bits [1:0] cleared and that step by 4. The value on `ad_o` is the `rd_data` returned for that address.
- R8: The edge on which a word transfers while `txn_n` is 1 is the last edge of the cycle. On the next clock `sel_n` and `slv_rdy_n` are 1 and `ad_oe` is 0.
- R9: `par_oe` is `ad_oe` delayed by one clock. While `par_oe` is 1, `par_o` equals the XOR of all bits of `ad_o` and `cbe_i` from the previous clock, so that data, byte enables and parity hold an even number of ones.
- R10: A start edge is an edge where `txn_n` is 0 after an edge where both `txn_n` and `mst_rdy_n` were 1. The values on `ad_i` and `cbe_i` during data words never start or restart a claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| txn_n | input | 1 | Cycle-in-progress indication from the initiator, active low |
| mst_rdy_n | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data lines as seen at the pads |
| cbe_i | input | 4 | Command in the address phase, byte enables in data phases |
| ad_o | output | 32 | Data value driven on the address/data lines |
| ad_oe | output | 1 | Output enable for the address/data lines |
| slv_rdy_n | output | 1 | Target ready, active low |
| sel_n | output | 1 | Cycle claimed by this target, active low |
| par_o | output | 1 | Even parity value for the previous driven data clock |
| par_oe | output | 1 | Output enable for the parity line |
| rd_req | output | 1 | Local port: a word is wanted at `rd_addr` |
| rd_addr | output | 32 | Local port: byte address of the wanted word |
| rd_valid | input | 1 | Local port: `rd_data` is valid for `rd_addr` this clock |
| rd_data | input | 32 | Local port: returned word |

## Verification
The bench targets the turnaround clock. A responder that drives data or raises ready there would show `ad_oe` or `slv_rdy_n` active one clock early. Bursts combine two kinds of stall, an initiator that is not ready and a local port that is not ready. A design that moves a word on a one-sided handshake, or that fails to hold its word, pops the scoreboard out of step or delivers the wrong address's data. Decoy values that look like an in-window read are placed on `ad_i`/`cbe_i` during data clocks, and out-of-window and non-read cycles are also run, to expose a false claim or a restart. The parity line is compared against a reference computed on all four byte lanes under varying byte enables, which exposes a parity that is late, masked by byte enables, or odd.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    localparam int BUS_W  = 32;
    localparam int BE_W   = BUS_W / 8;
    localparam int STEP_B = BE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_DATA = 2'd2
    } rdt_state_e;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BE_W-1:0]  cmd;
    } rdt_addr_ph_t;

    localparam logic [BE_W-1:0] CMD_MEM_READ  = 4'b0110;
    localparam logic [BE_W-1:0] CMD_READ_MULT = 4'b1100;
    localparam logic [BE_W-1:0] CMD_READ_LINE = 4'b1110;

    function automatic logic is_read_cmd(input logic [BE_W-1:0] c);
        return (c == CMD_MEM_READ) || (c == CMD_READ_MULT) || (c == CMD_READ_LINE);
    endfunction

    function automatic logic even_par(input logic [BUS_W-1:0] d, input logic [BE_W-1:0] be);
        return ^{d, be};
    endfunction

endpackage

// File: rtl/rdt_decode.sv
module rdt_decode
    import rdt_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h8000_0000,
    parameter int               WIN_BITS  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_n,
    input  logic             mst_rdy_n,
    input  logic [BUS_W-1:0] ad_i,
    input  logic [BE_W-1:0]  cbe_i,
    output logic             claim,
    output rdt_addr_ph_t     addr_ph
);

    logic prev_txn_n;
    logic prev_mrdy_n;
    logic start;
    logic in_window;

    // Bus idle on the previous edge: both the cycle and ready lines were high.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_txn_n  <= 1'b1;
            prev_mrdy_n <= 1'b1;
        end else begin
            prev_txn_n  <= txn_n;
            prev_mrdy_n <= mst_rdy_n;
        end
    end

    always_comb begin
        start        = !txn_n && prev_txn_n && prev_mrdy_n;
        in_window    = (ad_i[BUS_W-1:WIN_BITS] == BASE_ADDR[BUS_W-1:WIN_BITS]);
        addr_ph.addr = ad_i;
        addr_ph.cmd  = cbe_i;
        claim        = start && in_window && is_read_cmd(cbe_i);
    end

    // R10: a start edge needs the bus idle one edge earlier.
    assert_start_after_idle_R10: assert property (@(posedge clk) disable iff (rst)
        claim |-> $past(txn_n) && $past(mst_rdy_n));

endmodule

// File: rtl/rdt_beat_ctrl.sv
module rdt_beat_ctrl
    import rdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             claim,
    input  rdt_addr_ph_t     addr_ph,
    input  logic             txn_n,
    input  logic             mst_rdy_n,
    input  logic             rd_valid,
    input  logic [BUS_W-1:0] rd_data,
    output logic             rd_req,
    output logic [BUS_W-1:0] rd_addr,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe,
    output logic             slv_rdy_n,
    output logic             sel_n
);

    localparam logic [BUS_W-1:0] STEP = BUS_W'(STEP_B);

    rdt_state_e       state;
    logic [BUS_W-1:0] beat_addr;
    logic             xfer;
    logic             last;
    logic             load;

    always_comb begin
        xfer    = (state == ST_DATA) && !slv_rdy_n && !mst_rdy_n;
        last    = txn_n;
        rd_req  = (state == ST_TURN)
               || ((state == ST_DATA) && slv_rdy_n)
               || (xfer && !last);
        rd_addr = xfer ? beat_addr + STEP : beat_addr;
        load    = rd_req && rd_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            beat_addr <= '0;
            ad_o      <= '0;
            ad_oe     <= 1'b0;
            sel_n     <= 1'b1;
            slv_rdy_n <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (claim) begin
                        beat_addr <= {addr_ph.addr[BUS_W-1:2], 2'b00};
                        state     <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    // Turnaround over: claim and start driving the lines.
                    state <= ST_DATA;
                    sel_n <= 1'b0;
                    ad_oe <= 1'b1;
                    if (load) begin
                        ad_o      <= rd_data;
                        slv_rdy_n <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (xfer && last) begin
                        state     <= ST_IDLE;
                        sel_n     <= 1'b1;
                        slv_rdy_n <= 1'b1;
                        ad_oe     <= 1'b0;
                    end else if (xfer) begin
                        beat_addr <= beat_addr + STEP;
                        if (load) begin
                            ad_o      <= rd_data;
                            slv_rdy_n <= 1'b0;
                        end else begin
                            slv_rdy_n <= 1'b1;
                        end
                    end else if (slv_rdy_n && load) begin
                        ad_o      <= rd_data;
                        slv_rdy_n <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_turnaround_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && claim) |=> (sel_n && slv_rdy_n && !ad_oe));

    assert_ready_inside_claim_R4: assert property (@(posedge clk) disable iff (rst)
        !slv_rdy_n |-> (!sel_n && ad_oe));

    assert_hold_word_R5: assert property (@(posedge clk) disable iff (rst)
        (!slv_rdy_n && mst_rdy_n) |=> (!slv_rdy_n && $stable(ad_o)));

    assert_wait_local_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && slv_rdy_n && !rd_valid) |=> slv_rdy_n);

    assert_release_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (!slv_rdy_n && !mst_rdy_n && txn_n) |=> (sel_n && slv_rdy_n && !ad_oe));

endmodule

// File: rtl/rdt_parity.sv
module rdt_parity
    import rdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] ad_o,
    input  logic [BE_W-1:0]  cbe_i,
    input  logic             ad_oe,
    output logic             par_o,
    output logic             par_oe
);

    // All four lanes count, whatever the byte enables say.
    always_ff @(posedge clk) begin
        if (rst) begin
            par_o  <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par_o  <= even_par(ad_o, cbe_i);
            par_oe <= ad_oe;
        end
    end

endmodule

// File: rtl/bus_read_target.sv
module bus_read_target
    import rdt_pkg::*;
#(
    parameter logic [BUS_W-1:0] BASE_ADDR = 32'h8000_0000,
    parameter int               WIN_BITS  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             txn_n,
    input  logic             mst_rdy_n,
    input  logic [BUS_W-1:0] ad_i,
    input  logic [BE_W-1:0]  cbe_i,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe,
    output logic             slv_rdy_n,
    output logic             sel_n,
    output logic             par_o,
    output logic             par_oe,
    output logic             rd_req,
    output logic [BUS_W-1:0] rd_addr,
    input  logic             rd_valid,
    input  logic [BUS_W-1:0] rd_data
);

    logic         claim;
    rdt_addr_ph_t addr_ph;

    rdt_decode #(
        .BASE_ADDR (BASE_ADDR),
        .WIN_BITS  (WIN_BITS)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .txn_n     (txn_n),
        .mst_rdy_n (mst_rdy_n),
        .ad_i      (ad_i),
        .cbe_i     (cbe_i),
        .claim     (claim),
        .addr_ph   (addr_ph)
    );

    rdt_beat_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .claim     (claim),
        .addr_ph   (addr_ph),
        .txn_n     (txn_n),
        .mst_rdy_n (mst_rdy_n),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .ad_o      (ad_o),
        .ad_oe     (ad_oe),
        .slv_rdy_n (slv_rdy_n),
        .sel_n     (sel_n)
    );

    rdt_parity u_parity (
        .clk    (clk),
        .rst    (rst),
        .ad_o   (ad_o),
        .cbe_i  (cbe_i),
        .ad_oe  (ad_oe),
        .par_o  (par_o),
        .par_oe (par_oe)
    );

    // R9: parity drive follows a claimed clock by one edge.
    assert_par_follows_claim_R9: assert property (@(posedge clk) disable iff (rst)
        !sel_n |=> par_oe);

endmodule

// File: tb/bus_read_target_tb.sv
module bus_read_target_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h8000_0000;
    localparam int          WIN        = 12;

    logic        clk = 1'b0;
    logic        rst;
    logic        txn_n, mst_rdy_n;
    logic [31:0] ad_i;
    logic [3:0]  cbe_i;
    logic [31:0] ad_o;
    logic        ad_oe, slv_rdy_n, sel_n, par_o, par_oe;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_valid;
    logic [31:0] rd_data;

    int          n_cmp = 0;
    int          n_err = 0;
    logic [31:0] exp_q[$];
    logic [7:0]  ready_pat;
    int          pidx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
    endfunction

    assign rd_data = mem_word(rd_addr);

    bus_read_target #(.BASE_ADDR(BASE), .WIN_BITS(WIN)) u_dut (
        .clk(clk), .rst(rst), .txn_n(txn_n), .mst_rdy_n(mst_rdy_n),
        .ad_i(ad_i), .cbe_i(cbe_i), .ad_o(ad_o), .ad_oe(ad_oe),
        .slv_rdy_n(slv_rdy_n), .sel_n(sel_n), .par_o(par_o), .par_oe(par_oe),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    // All input changes happen on the falling edge.
    task automatic tick();
        @(negedge clk);
        pidx++;
        rd_valid = ready_pat[pidx % 8];
    endtask

    // Monitor: scoreboard pops plus per-clock protocol checks.
    initial begin
        logic prev_oe, prev_par, have_prev, prev_trdy_n, prev_xfer, prev_valid, xfer_now;
        logic [31:0] exp_w;
        have_prev = 0; prev_trdy_n = 1; prev_xfer = 0; prev_valid = 0; prev_oe = 0; prev_par = 0;
        forever begin
            @(negedge clk);
            #1;
            if (rst) begin
                have_prev = 0; prev_trdy_n = 1; prev_xfer = 0; prev_valid = 0;
            end else begin
                if (have_prev) begin
                    chk(par_oe == prev_oe, "R9 parity enable", {31'b0, par_oe}, {31'b0, prev_oe});
                    if (prev_oe)
                        chk(par_o == prev_par, "R9 parity value", {31'b0, par_o}, {31'b0, prev_par});
                end
                prev_oe = ad_oe; prev_par = ^{ad_o, cbe_i}; have_prev = 1;
                chk(ad_oe == !sel_n, "R4 drive only while claimed", {31'b0, ad_oe}, {31'b0, !sel_n});
                if (!slv_rdy_n && (prev_trdy_n || prev_xfer))
                    chk(prev_valid, "R6 ready without local data", {31'b0, prev_valid}, 32'd1);
                xfer_now = !slv_rdy_n && !mst_rdy_n;
                if (xfer_now) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R5 unexpected transfer", ad_o, 32'h0);
                    end else begin
                        exp_w = exp_q.pop_front();
                        chk(ad_o == exp_w, "R7 word data", ad_o, exp_w);
                    end
                end
                prev_trdy_n = slv_rdy_n; prev_xfer = xfer_now; prev_valid = rd_valid;
            end
        end
    end

    task automatic run_read(input logic [31:0] addr, input logic [3:0] cmd, input int beats,
                            input logic [7:0] irdy_pat, input bit claimed, input int stall);
        int rem, cyc, guard;
        bit fin, first, xfer;
        logic [7:0] saved;
        saved = ready_pat;
        tick();
        txn_n = 0; mst_rdy_n = 1; ad_i = addr; cbe_i = cmd;
        if (claimed)
            for (int i = 0; i < beats; i++) exp_q.push_back(mem_word({addr[31:2], 2'b00} + 32'(4 * i)));
        if (stall > 0) ready_pat = 8'h00;
        tick();
        // Turnaround clock.
        chk(sel_n && slv_rdy_n && !ad_oe, "R3 turnaround quiet",
            {29'b0, sel_n, slv_rdy_n, ad_oe}, 32'b110);
        ad_i = BASE + 32'h40; cbe_i = 4'b0110;
        if (!claimed) begin
            txn_n = 1; mst_rdy_n = 0;
            for (int k = 0; k < 4; k++) begin
                tick();
                mst_rdy_n = 1;
                chk(sel_n && !ad_oe, "R2 no claim", {30'b0, sel_n, ad_oe}, 32'b10);
            end
            tick();
            return;
        end
        first = 1;
        if (stall > 0) begin
            txn_n = 0; mst_rdy_n = 0;
            for (int k = 0; k < stall; k++) begin
                tick();
                chk(!sel_n && slv_rdy_n, "R6 wait while local not ready",
                    {30'b0, sel_n, slv_rdy_n}, 32'b01);
            end
            first = 0;
            ready_pat = saved;
        end
        rem = beats; cyc = 0; guard = 0; fin = 0;
        while (rem > 0 && guard < 300) begin
            mst_rdy_n = fin ? 1'b0 : irdy_pat[cyc % 8];
            if (rem == 1 && !mst_rdy_n) begin
                fin = 1; txn_n = 1;
            end else begin
                txn_n = 0;
            end
            cbe_i = 4'(cyc) ^ 4'b0110;
            ad_i  = BASE + 32'h40 + 32'(cyc);
            xfer  = !slv_rdy_n && !mst_rdy_n;
            tick();
            cyc++; guard++;
            if (xfer) rem--;
            if (first) begin
                chk(!sel_n, "R2 claim two edges after start", {31'b0, sel_n}, 32'd0);
                first = 0;
            end
        end
        chk(sel_n && slv_rdy_n && !ad_oe, "R8 release after last word",
            {29'b0, sel_n, slv_rdy_n, ad_oe}, 32'b110);
        txn_n = 1; mst_rdy_n = 1;
        tick();
        chk(sel_n, "R10 no restart after cycle", {31'b0, sel_n}, 32'd1);
        chk(exp_q.size() == 0, "R5 word count", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        rst = 1; txn_n = 1; mst_rdy_n = 1; ad_i = '0; cbe_i = '0; rd_valid = 0; ready_pat = 8'hFF;
        repeat (4) tick();
        chk(sel_n && slv_rdy_n && !ad_oe && !par_oe, "R1 reset state",
            {28'b0, sel_n, slv_rdy_n, ad_oe, par_oe}, 32'b1100);
        rst = 0;
        tick();
        chk(sel_n && slv_rdy_n && !ad_oe && !par_oe, "R1 after reset",
            {28'b0, sel_n, slv_rdy_n, ad_oe, par_oe}, 32'b1100);
        // R2/R7: single word, all ready.
        run_read(BASE + 32'h100, 4'b0110, 1, 8'h00, 1, 0);
        // R7: four-word burst, unaligned start address.
        run_read(BASE + 32'h203, 4'b1100, 4, 8'h00, 1, 0);
        // R6: local wait states inside a burst.
        ready_pat = 8'b1010_0110;
        run_read(BASE + 32'h300, 4'b1110, 5, 8'h00, 1, 0);
        // R5: initiator wait states, word must hold.
        ready_pat = 8'hFF;
        run_read(BASE + 32'h400, 4'b0110, 5, 8'b0110_0100, 1, 0);
        // R5/R6 mixed stalls.
        ready_pat = 8'b1101_1011;
        run_read(BASE + 32'h500, 4'b1100, 6, 8'b0010_1010, 1, 0);
        // R6: long local stall before the first word.
        ready_pat = 8'hFF;
        run_read(BASE + 32'h600, 4'b0110, 2, 8'h00, 1, 6);
        // R2: write command inside the window.
        run_read(BASE + 32'h100, 4'b0111, 1, 8'h00, 0, 0);
        // R2: read outside the window.
        run_read(BASE + 32'h1000, 4'b0110, 1, 8'h00, 0, 0);
        // R2: I/O-style read code is not claimed.
        run_read(BASE + 32'h100, 4'b0010, 1, 8'h00, 0, 0);
        // R10: back-to-back cycles after a single idle clock.
        run_read(BASE + 32'hFFC, 4'b1110, 1, 8'h00, 1, 0);
        run_read(BASE + 32'h010, 4'b0110, 3, 8'b0000_0010, 1, 0);
        tick();
        summary();
    end

endmodule